// File: doc/BRIEF.md
# Expiration-Counting Watchdog with Unlocked Disable

This block pairs a small down-counting timer with a watchdog stage. Software programs the timer with a period and an auto-reload choice, then arms the watchdog with a start command. The watchdog counts the timer's expirations. It raises an interrupt on the first one, if enabled, and requests a reset on the fourth. Waiting for several expirations lets software use a short timer period while still getting a long grace time before a reset.

Software cannot stop a running watchdog by accident. A disable command works only when the write just before it put a fixed key into the unlock register. Any other write in between clears the unlock. Both reset request outputs are sticky levels, and only the block's own reset clears them.

All registers sit behind one simple port. Writes take effect on the clock edge where `bus_wr` is high. Reads are combinational on the selected address. `bus_tmr_sel` chooses between the timer space and the watchdog space.

Top module: `wdg_top`

## Requirements
- R1: After reset, `wd_irq`, `sys_rst_req` and `aux_rst_req` are low, and every readable register reads zero.
- R2: Timer space offset 0x0 is the reload register. Bit 31 enables the timer, bit 30 selects auto-reload, and bits 28:0 hold the period P. Once enabled, the timer expires P+1 cycles after the write and then every P+1 cycles while auto-reload is set. Reads return the written enable, auto-reload and period bits.
- R3: With auto-reload clear, the timer expires once and then clears its enable bit, which reads back as 0.
- R4: Writing zero to the reload register stops the timer, so no further expirations occur.
- R5: Timer space offset 0x4 is the status register. Its bit 30 is set on each expiration and is cleared by writing 1 to bit 30. Writing 0 there leaves it unchanged.
- R6: Watchdog space offset 0x0 is the config register. Bits 3:0 select the source, bit 12 enables the interrupt, bit 14 enables the system reset and bit 15 enables the auxiliary reset. All other bits read as 0. Only source value 0 (this timer) is counted; any other value counts nothing.
- R7: Watchdog offset 0x8 is the command register. Writing bit 0 starts the watchdog and clears both the expiration count and the interrupt.
- R8: The expiration is counted on the clock edge where it occurs. The fourth counted expiration after start sets `sys_rst_req` if bit 14 is set and `aux_rst_req` if bit 15 is set. Each output then stays high until block reset.
- R9: The first counted expiration after start sets `wd_irq` if bit 12 is set. `wd_irq` stays high until a start or an accepted disable.
- R10: Command bit 1 stops the watchdog only when the immediately preceding write put 0x0000C45A into watchdog offset 0xC. Any register write consumes the unlock, so a disable after any other write is ignored.
- R11: `bus_tmr_sel` high addresses the timer space and low addresses the watchdog space. The two spaces share no storage.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low block reset |
| bus_wr | input | 1 | Write strobe |
| bus_tmr_sel | input | 1 | 1 selects timer space, 0 selects watchdog space |
| bus_addr | input | ADDR_W | Byte offset within the selected space |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the addressed register |
| wd_irq | output | 1 | Watchdog interrupt level |
| sys_rst_req | output | 1 | Sticky system reset request |
| aux_rst_req | output | 1 | Sticky auxiliary reset request |

## Verification
The bench keeps the default parameters: a 29-bit period field and an expiration limit of 4. The period is a runtime value, so the bench programs periods of 3 to 9 cycles. This lets the fourth expiration, a restart partway through the count, and the disable sequences all finish within a few dozen cycles. With expirations at a known phase from the reload write, the interrupt and reset edges are checked on the exact cycle on either side.

// File: rtl/wdg_pkg.sv
package wdg_pkg;
  localparam int REG_W = 32;

  localparam logic [3:0] OFS_RELOAD = 4'h0;
  localparam logic [3:0] OFS_STATUS = 4'h4;
  localparam logic [3:0] OFS_CFG    = 4'h0;
  localparam logic [3:0] OFS_CMD    = 4'h8;
  localparam logic [3:0] OFS_UNLOCK = 4'hC;

  localparam int BIT_TMR_EN   = 31;
  localparam int BIT_TMR_AUTO = 30;
  localparam int BIT_PENDING  = 30;
  localparam int BIT_IRQ_EN   = 12;
  localparam int BIT_SYS_EN   = 14;
  localparam int BIT_AUX_EN   = 15;
  localparam int BIT_START    = 0;
  localparam int BIT_STOP     = 1;

  localparam logic [REG_W-1:0] UNLOCK_KEY = 32'h0000_C45A;

  typedef struct packed {
    logic       aux_en;
    logic       sys_en;
    logic       irq_en;
    logic [3:0] src;
  } wd_cfg_t;

  function automatic wd_cfg_t cfg_from_word(input logic [REG_W-1:0] w);
    wd_cfg_t c;
    c.aux_en = w[BIT_AUX_EN];
    c.sys_en = w[BIT_SYS_EN];
    c.irq_en = w[BIT_IRQ_EN];
    c.src    = w[3:0];
    return c;
  endfunction

  function automatic logic [REG_W-1:0] cfg_to_word(input wd_cfg_t c);
    logic [REG_W-1:0] w;
    w = '0;
    w[BIT_AUX_EN] = c.aux_en;
    w[BIT_SYS_EN] = c.sys_en;
    w[BIT_IRQ_EN] = c.irq_en;
    w[3:0]        = c.src;
    return w;
  endfunction
endpackage

// File: rtl/wdg_timer.sv
module wdg_timer
  import wdg_pkg::*;
#(
  parameter int PERIOD_W = 29
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_reload,
  input  logic                wr_status,
  input  logic [REG_W-1:0]    wdata,
  output logic                tmr_en,
  output logic                tmr_auto,
  output logic [PERIOD_W-1:0] tmr_period,
  output logic                tmr_pending,
  output logic                tmr_expire
);
  logic [PERIOD_W-1:0] cnt_q;

  function automatic logic [PERIOD_W-1:0] tick_down(input logic [PERIOD_W-1:0] v);
    return v - PERIOD_W'(1);
  endfunction

  assign tmr_expire = tmr_en && (cnt_q == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tmr_en      <= 1'b0;
      tmr_auto    <= 1'b0;
      tmr_period  <= '0;
      cnt_q       <= '0;
      tmr_pending <= 1'b0;
    end else begin
      if (wr_reload) begin
        tmr_en     <= wdata[BIT_TMR_EN];
        tmr_auto   <= wdata[BIT_TMR_AUTO];
        tmr_period <= wdata[PERIOD_W-1:0];
        cnt_q      <= wdata[PERIOD_W-1:0];
      end else if (tmr_expire) begin
        if (tmr_auto) cnt_q  <= tmr_period;
        else          tmr_en <= 1'b0;
      end else if (tmr_en) begin
        cnt_q <= tick_down(cnt_q);
      end

      if (tmr_expire)                          tmr_pending <= 1'b1;
      else if (wr_status && wdata[BIT_PENDING]) tmr_pending <= 1'b0;
    end
  end
endmodule

// File: rtl/wdg_stage.sv
module wdg_stage
  import wdg_pkg::*;
#(
  parameter int EXPIRE_LIMIT = 4,
  localparam int CNT_W = $clog2(EXPIRE_LIMIT + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_any,
  input  logic             wr_cfg,
  input  logic             wr_cmd,
  input  logic             wr_unlock,
  input  logic [REG_W-1:0] wdata,
  input  logic             expire,
  output wd_cfg_t          cfg,
  output logic             active,
  output logic             armed,
  output logic [CNT_W-1:0] count,
  output logic             count_evt,
  output logic             fire,
  output logic             stop_ok,
  output logic             start_req,
  output logic             irq,
  output logic             sys_rst,
  output logic             aux_rst
);
  function automatic logic is_last(input logic [CNT_W-1:0] c);
    return c == CNT_W'(EXPIRE_LIMIT - 1);
  endfunction

  assign stop_ok   = wr_cmd && wdata[BIT_STOP] && armed;
  assign start_req = wr_cmd && wdata[BIT_START] && !stop_ok;
  assign count_evt = active && expire && (cfg.src == 4'd0)
                     && (count < CNT_W'(EXPIRE_LIMIT)) && !start_req;
  assign fire      = count_evt && is_last(count);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg     <= '0;
      active  <= 1'b0;
      armed   <= 1'b0;
      count   <= '0;
      irq     <= 1'b0;
      sys_rst <= 1'b0;
      aux_rst <= 1'b0;
    end else begin
      if (wr_cfg) cfg <= cfg_from_word(wdata);
      if (wr_any) armed <= wr_unlock && (wdata == UNLOCK_KEY);

      if (stop_ok)        active <= 1'b0;
      else if (start_req) active <= 1'b1;

      if (start_req)      count <= '0;
      else if (count_evt) count <= count + CNT_W'(1);

      if (stop_ok || start_req)                    irq <= 1'b0;
      else if (count_evt && count == '0 && cfg.irq_en) irq <= 1'b1;

      if (fire && cfg.sys_en) sys_rst <= 1'b1;
      if (fire && cfg.aux_en) aux_rst <= 1'b1;
    end
  end
endmodule

// File: rtl/wdg_top.sv
module wdg_top
  import wdg_pkg::*;
#(
  parameter int PERIOD_W     = 29,
  parameter int EXPIRE_LIMIT = 4,
  parameter int ADDR_W       = 4,
  localparam int CNT_W = $clog2(EXPIRE_LIMIT + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic              bus_tmr_sel,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [REG_W-1:0]  bus_wdata,
  output logic [REG_W-1:0]  bus_rdata,
  output logic              wd_irq,
  output logic              sys_rst_req,
  output logic              aux_rst_req
);
  logic [3:0] ofs;
  assign ofs = 4'(bus_addr);

  logic wr_reload, wr_status, wr_cfg, wr_cmd, wr_unlock;
  assign wr_reload = bus_wr &&  bus_tmr_sel && ofs == OFS_RELOAD;
  assign wr_status = bus_wr &&  bus_tmr_sel && ofs == OFS_STATUS;
  assign wr_cfg    = bus_wr && !bus_tmr_sel && ofs == OFS_CFG;
  assign wr_cmd    = bus_wr && !bus_tmr_sel && ofs == OFS_CMD;
  assign wr_unlock = bus_wr && !bus_tmr_sel && ofs == OFS_UNLOCK;

  logic                tmr_en, tmr_auto, tmr_pending, tmr_expire;
  logic [PERIOD_W-1:0] tmr_period;
  wd_cfg_t             wd_cfg;
  logic                wd_active, wd_armed, wd_count_evt, wd_fire;
  logic                wd_stop_ok, wd_start_req;
  logic [CNT_W-1:0]    wd_count;

  wdg_timer #(.PERIOD_W(PERIOD_W)) u_timer (
    .clk(clk), .rst_n(rst_n),
    .wr_reload(wr_reload), .wr_status(wr_status), .wdata(bus_wdata),
    .tmr_en(tmr_en), .tmr_auto(tmr_auto), .tmr_period(tmr_period),
    .tmr_pending(tmr_pending), .tmr_expire(tmr_expire)
  );

  wdg_stage #(.EXPIRE_LIMIT(EXPIRE_LIMIT)) u_stage (
    .clk(clk), .rst_n(rst_n),
    .wr_any(bus_wr), .wr_cfg(wr_cfg), .wr_cmd(wr_cmd), .wr_unlock(wr_unlock),
    .wdata(bus_wdata), .expire(tmr_expire),
    .cfg(wd_cfg), .active(wd_active), .armed(wd_armed), .count(wd_count),
    .count_evt(wd_count_evt), .fire(wd_fire),
    .stop_ok(wd_stop_ok), .start_req(wd_start_req),
    .irq(wd_irq), .sys_rst(sys_rst_req), .aux_rst(aux_rst_req)
  );

  always_comb begin
    bus_rdata = '0;
    if (bus_tmr_sel) begin
      if (ofs == OFS_RELOAD) begin
        bus_rdata[BIT_TMR_EN]     = tmr_en;
        bus_rdata[BIT_TMR_AUTO]   = tmr_auto;
        bus_rdata[PERIOD_W-1:0]   = tmr_period;
      end else if (ofs == OFS_STATUS) begin
        bus_rdata[BIT_PENDING]    = tmr_pending;
      end
    end else if (ofs == OFS_CFG) begin
      bus_rdata = cfg_to_word(wd_cfg);
    end
  end
endmodule

// File: rtl/wdg_checker.sv
module wdg_checker
  import wdg_pkg::*;
#(
  parameter int EXPIRE_LIMIT = 4,
  parameter int CNT_W = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             bus_wr,
  input logic             wr_cmd,
  input logic             wr_unlock,
  input logic             wr_reload,
  input logic [REG_W-1:0] bus_wdata,
  input logic             tmr_expire,
  input logic             tmr_auto,
  input logic             tmr_en,
  input wd_cfg_t          wd_cfg,
  input logic             wd_active,
  input logic             wd_armed,
  input logic [CNT_W-1:0] wd_count,
  input logic             wd_count_evt,
  input logic             wd_fire,
  input logic             wd_irq,
  input logic             sys_rst_req,
  input logic             aux_rst_req
);
  a_r8_sys_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    sys_rst_req |=> sys_rst_req);
  a_r8_aux_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    aux_rst_req |=> aux_rst_req);
  a_r8_sys_gated: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sys_rst_req) |-> $past(wd_fire && wd_cfg.sys_en));
  a_r8_aux_gated: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(aux_rst_req) |-> $past(wd_fire && wd_cfg.aux_en));
  a_r9_irq_gated: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wd_irq) |-> $past(wd_count_evt && wd_cfg.irq_en));
  a_r10_stop_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_cmd && bus_wdata[BIT_STOP] && !bus_wdata[BIT_START] && !wd_armed)
      |=> wd_active == $past(wd_active));
  a_r10_unlock_consumed: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && !wr_unlock) |=> !wd_armed);
  a_r3_one_shot_stops: assert property (@(posedge clk) disable iff (!rst_n)
    (tmr_expire && !tmr_auto && !wr_reload) |=> !tmr_en);
  a_r7_count_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    wd_count <= CNT_W'(EXPIRE_LIMIT));
endmodule

bind wdg_top wdg_checker #(.EXPIRE_LIMIT(EXPIRE_LIMIT), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .wr_cmd(wr_cmd),
  .wr_unlock(wr_unlock), .wr_reload(wr_reload), .bus_wdata(bus_wdata),
  .tmr_expire(tmr_expire), .tmr_auto(tmr_auto), .tmr_en(tmr_en),
  .wd_cfg(wd_cfg), .wd_active(wd_active), .wd_armed(wd_armed),
  .wd_count(wd_count), .wd_count_evt(wd_count_evt), .wd_fire(wd_fire),
  .wd_irq(wd_irq), .sys_rst_req(sys_rst_req), .aux_rst_req(aux_rst_req)
);

// File: tb/wdg_top_test.sv
`timescale 1ns/1ps
module wdg_top_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic        bus_tmr_sel = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        wd_irq, sys_rst_req, aux_rst_req;
  int checks = 0;
  int failures = 0;
  logic [31:0] rv;

  always #2 clk = ~clk;

  wdg_top uut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_tmr_sel(bus_tmr_sel),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .wd_irq(wd_irq), .sys_rst_req(sys_rst_req), .aux_rst_req(aux_rst_req)
  );

  localparam logic [31:0] EN = 32'h8000_0000, AUTO = 32'h4000_0000, PEND = 32'h4000_0000;
  localparam logic [31:0] IRQ_EN = 32'h1000, SYS_EN = 32'h4000, AUX_EN = 32'h8000;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic tsel, input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_tmr_sel = tsel; bus_addr = a; bus_wdata = d;
    @(posedge clk); #1;
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic tsel, input logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_tmr_sel = tsel; bus_addr = a;
    #0.5 d = bus_rdata;
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
  endtask

  task automatic t_reset_and_spaces();
    do_reset();
    check("R1 irq", {31'b0, wd_irq}, 0);
    check("R1 sys", {31'b0, sys_rst_req}, 0);
    check("R1 aux", {31'b0, aux_rst_req}, 0);
    rd(1, 4'h0, rv); check("R1 reload", rv, 0);
    rd(1, 4'h4, rv); check("R1 status", rv, 0);
    rd(0, 4'h0, rv); check("R1 cfg", rv, 0);
    wr(0, 4'h0, 32'hFFFF_FFFF);
    rd(0, 4'h0, rv); check("R6 cfg fields", rv, 32'h0000_D00F);
    rd(1, 4'h0, rv); check("R11 timer space untouched", rv, 0);
    wr(1, 4'h0, 32'h0000_0123);
    rd(1, 4'h0, rv); check("R2 reload readback", rv, 32'h0000_0123);
    rd(0, 4'h0, rv); check("R11 wd space untouched", rv, 32'h0000_D00F);
  endtask

  task automatic t_periodic();
    do_reset();
    wr(1, 4'h0, EN | AUTO | 32'd5);
    wait_cyc(5); rd(1, 4'h4, rv); check("R2 no expiry before P+1", rv, 0);
    wait_cyc(1); rd(1, 4'h4, rv); check("R5 pending on expiry", rv, PEND);
    wr(1, 4'h4, PEND);
    rd(1, 4'h4, rv); check("R5 cleared by 1", rv, 0);
    wait_cyc(6); rd(1, 4'h4, rv); check("R2 periodic re-expiry", rv, PEND);
    wr(1, 4'h4, 32'h0);
    rd(1, 4'h4, rv); check("R5 write 0 no effect", rv, PEND);
    wr(1, 4'h0, 32'h0);
    wr(1, 4'h4, PEND);
    wait_cyc(20); rd(1, 4'h4, rv); check("R4 zero stops timer", rv, 0);
  endtask

  task automatic t_one_shot();
    do_reset();
    wr(1, 4'h0, EN | 32'd3);
    wait_cyc(10);
    rd(1, 4'h0, rv); check("R3 enable cleared", rv, 32'd3);
    rd(1, 4'h4, rv); check("R3 expired once", rv, PEND);
    wr(1, 4'h4, PEND);
    wait_cyc(20); rd(1, 4'h4, rv); check("R3 no second expiry", rv, 0);
  endtask

  task automatic t_fourth_expiry();
    do_reset();
    wr(0, 4'h0, IRQ_EN | SYS_EN | AUX_EN);
    wr(0, 4'h8, 32'h1);
    wr(1, 4'h0, EN | AUTO | 32'd9);
    wait_cyc(9);  check("R9 irq not before first", {31'b0, wd_irq}, 0);
    wait_cyc(1);  check("R9 irq on first expiry", {31'b0, wd_irq}, 1);
    wait_cyc(29); check("R8 no reset on third", {31'b0, sys_rst_req}, 0);
    wait_cyc(1);  check("R8 sys on fourth", {31'b0, sys_rst_req}, 1);
    check("R8 aux on fourth", {31'b0, aux_rst_req}, 1);
    wr(1, 4'h0, 32'h0);
    wait_cyc(20); check("R8 sys held", {31'b0, sys_rst_req}, 1);
  endtask

  task automatic t_enables_gate();
    do_reset();
    wr(0, 4'h0, AUX_EN);
    wr(0, 4'h8, 32'h1);
    wr(1, 4'h0, EN | AUTO | 32'd9);
    wait_cyc(45);
    check("R9 irq off when disabled", {31'b0, wd_irq}, 0);
    check("R8 sys gated by bit14", {31'b0, sys_rst_req}, 0);
    check("R8 aux by bit15", {31'b0, aux_rst_req}, 1);
  endtask

  task automatic t_restart_clears();
    do_reset();
    wr(0, 4'h0, IRQ_EN | SYS_EN);
    wr(0, 4'h8, 32'h1);
    wr(1, 4'h0, EN | AUTO | 32'd9);
    wait_cyc(33);
    wr(0, 4'h8, 32'h1);
    check("R7 start clears irq", {31'b0, wd_irq}, 0);
    wait_cyc(30); check("R7 count restarted", {31'b0, sys_rst_req}, 0);
    wait_cyc(10); check("R7 fourth after restart", {31'b0, sys_rst_req}, 1);
  endtask

  task automatic t_stop_rules();
    do_reset();
    wr(0, 4'h0, SYS_EN);
    wr(0, 4'h8, 32'h1);
    wr(1, 4'h0, EN | AUTO | 32'd9);
    wr(0, 4'h8, 32'h2);
    wait_cyc(60); check("R10 stop without unlock ignored", {31'b0, sys_rst_req}, 1);

    do_reset();
    wr(0, 4'h0, SYS_EN);
    wr(0, 4'h8, 32'h1);
    wr(1, 4'h0, EN | AUTO | 32'd9);
    wr(0, 4'hC, 32'h0000_C45A);
    wr(1, 4'h4, PEND);
    wr(0, 4'h8, 32'h2);
    wait_cyc(60); check("R10 unlock consumed by other write", {31'b0, sys_rst_req}, 1);

    do_reset();
    wr(0, 4'h0, SYS_EN | IRQ_EN);
    wr(0, 4'h8, 32'h1);
    wr(1, 4'h0, EN | AUTO | 32'd9);
    wait_cyc(15); check("R9 irq before stop", {31'b0, wd_irq}, 1);
    wr(0, 4'hC, 32'h0000_C45A);
    wr(0, 4'h8, 32'h2);
    check("R9 stop clears irq", {31'b0, wd_irq}, 0);
    wait_cyc(60); check("R10 unlocked stop works", {31'b0, sys_rst_req}, 0);

    do_reset();
    wr(0, 4'h0, SYS_EN | 32'h1);
    wr(0, 4'h8, 32'h1);
    wr(1, 4'h0, EN | AUTO | 32'd3);
    wait_cyc(40); check("R6 nonzero source not counted", {31'b0, sys_rst_req}, 0);
  endtask

  initial begin
    fork
      begin
        t_reset_and_spaces();
        t_periodic();
        t_one_shot();
        t_fourth_expiry();
        t_enables_gate();
        t_restart_clears();
        t_stop_rules();
      end
      begin
        repeat (20000) @(posedge clk);
        checks++; failures++;
        $display("FAIL watchdog expired actual=hung expected=done");
      end
    join_any
    disable fork;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule